// File: doc/BRIEF.md
# Memory Operation Ordering Matrix

This block keeps order between the memory operations that are in flight at the same time in an out-of-order core. Each slot holds one load or store, a short tag cut from its address, an optional full-fence mark, and its age relative to every other slot. From this state the block works out, for each slot, whether that operation may touch memory now. It drives one read-permit bit per slot for loads and one write-permit bit per slot for stores. These bits feed the function-unit dependency matrix as extra blocking terms, and no permit is consumed inside the block.

Hazards are judged conservatively. Two operations are taken to clash when the low `CMP_BITS` of their addresses are equal. An alias in those bits adds delay but never lets a true clash through. A load waits for older stores it might clash with, and a store waits for older loads it might clash with. Stores stay in order among themselves, and loads never hold back other loads. Slots are allocated and freed by index, and several slots can be live at once.

Top module: `mo_order_matrix`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rd_permit` and `wr_permit` are all zero. All slots are empty and all age relations are cleared.
- R2: An allocation takes effect at the next clock edge. From then on, a slot holding a load (`alloc_store`=0) with nothing to wait on shows `rd_permit[slot]`=1. A slot holding a store (`alloc_store`=1) with nothing to wait on shows `wr_permit[slot]`=1. A slot never has both permits set, and an empty slot has neither.
- R3: A load is held (`rd_permit`=0) while any older live store has the same low `CMP_BITS` address bits. It is released in the cycle after the last such store is freed.
- R4: A store is held (`wr_permit`=0) while any older live load has the same low `CMP_BITS` address bits. It is released in the cycle after the last such load is freed.
- R5: A load and a store whose low `CMP_BITS` address bits differ do not hold each other.
- R6: Address bits at or above `CMP_BITS` take no part in the comparison. Two operations that differ only there are treated as clashing.
- R7: A load never holds another load, whatever their addresses.
- R8: A store is held while any older store is live, whatever their addresses. At most one store has its write permit at a time.
- R9: Only older slots can hold a slot. A live slot with no older live slot always has its permit.
- R10: A slot allocated with `alloc_fence`=1 is held until every slot that was live when it was allocated has been freed. Slots allocated after it are not held by the fence itself.
- R11: An allocation that names a slot that is already live is ignored, and that slot's contents are unchanged.
- R12: A free clears the slot and its age relations. A slot freed in the same cycle as another slot's allocation does not count as older than it. A reused slot counts as younger than every slot that was live when it was allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_en | input | 1 | Allocate a slot this cycle |
| alloc_slot | input | SLOT_W | Index of the slot to allocate |
| alloc_store | input | 1 | 1 = store, 0 = load |
| alloc_fence | input | 1 | Hold this operation behind every currently live slot |
| alloc_addr | input | ADDR_W | Operation address; only the low CMP_BITS are kept |
| free_en | input | 1 | Free a slot this cycle |
| free_slot | input | SLOT_W | Index of the slot to free |
| rd_permit | output | NUM_SLOTS | Per-slot permit for a load to read |
| wr_permit | output | NUM_SLOTS | Per-slot permit for a store to write |

## Verification
The bench builds the block with its defaults: four slots, a 16-bit address and a 4-bit compare tag. Four slots are enough to have a fence, an older store, an older load and a younger load live together. With a 4-bit tag, the bench can pick addresses that alias in the low nibble while differing above it, and so reach the conservative false-alarm case. The vector walk steps through hold and release for every load/store pairing, the rejection of an allocation to a live slot, and slot reuse. Directed tests then cover reset in the middle of traffic and a free and an allocation in the same cycle.

// File: rtl/mo_pkg.sv
`timescale 1ns/1ps
package mo_pkg;

    typedef enum logic {
        MEM_LOAD  = 1'b0,
        MEM_STORE = 1'b1
    } mem_kind_e;

    // Decide whether a younger operation must wait on an older live one.
    function automatic logic must_wait(
        input mem_kind_e young_kind,
        input mem_kind_e old_kind,
        input logic      young_fence,
        input logic      tags_equal
    );
        logic young_st;
        logic old_st;
        young_st = (young_kind == MEM_STORE);
        old_st   = (old_kind == MEM_STORE);
        return young_fence
             | (young_st & old_st)
             | ((young_st ^ old_st) & tags_equal);
    endfunction

endpackage

// File: rtl/mo_slot_file.sv
`timescale 1ns/1ps
module mo_slot_file
    import mo_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int CMP_BITS  = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               alloc_en,
    input  logic [SLOT_W-1:0]                  alloc_slot,
    input  mem_kind_e                          alloc_kind,
    input  logic                               alloc_fence,
    input  logic [CMP_BITS-1:0]                alloc_tag,
    input  logic                               free_en,
    input  logic [SLOT_W-1:0]                  free_slot,
    output logic                               alloc_take,
    output logic [NUM_SLOTS-1:0]               slot_valid,
    output mem_kind_e [NUM_SLOTS-1:0]          slot_kind,
    output logic [NUM_SLOTS-1:0]               slot_fence,
    output logic [NUM_SLOTS-1:0][CMP_BITS-1:0] slot_tag
);

    // A request to a live slot is dropped.
    assign alloc_take = alloc_en && !slot_valid[alloc_slot];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic hit_alloc;
        logic hit_free;
        assign hit_alloc = alloc_take && (alloc_slot == SLOT_W'(s));
        assign hit_free  = free_en && (free_slot == SLOT_W'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_valid[s] <= 1'b0;
                slot_kind[s]  <= MEM_LOAD;
                slot_fence[s] <= 1'b0;
                slot_tag[s]   <= '0;
            end else if (hit_alloc) begin
                slot_valid[s] <= 1'b1;
                slot_kind[s]  <= alloc_kind;
                slot_fence[s] <= alloc_fence;
                slot_tag[s]   <= alloc_tag;
            end else if (hit_free) begin
                slot_valid[s] <= 1'b0;
                slot_fence[s] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mo_age_matrix.sv
`timescale 1ns/1ps
module mo_age_matrix #(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              alloc_take,
    input  logic [SLOT_W-1:0]                 alloc_slot,
    input  logic                              free_en,
    input  logic [SLOT_W-1:0]                 free_slot,
    input  logic [NUM_SLOTS-1:0]              slot_valid,
    // older[y][o] = 1 when slot o was allocated before slot y
    output logic [NUM_SLOTS-1:0][NUM_SLOTS-1:0] older
);

    // Slots that are still live after this cycle's free.
    logic [NUM_SLOTS-1:0] survive;
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_survive
        assign survive[s] = slot_valid[s] && !(free_en && free_slot == SLOT_W'(s));
    end

    for (genvar y = 0; y < NUM_SLOTS; y++) begin : g_row
        for (genvar o = 0; o < NUM_SLOTS; o++) begin : g_col
            if (y == o) begin : g_diag
                assign older[y][o] = 1'b0;
            end else begin : g_cell
                logic row_alloc;
                logic col_alloc;
                logic touch_free;
                assign row_alloc  = alloc_take && (alloc_slot == SLOT_W'(y));
                assign col_alloc  = alloc_take && (alloc_slot == SLOT_W'(o));
                assign touch_free = free_en &&
                                    (free_slot == SLOT_W'(y) || free_slot == SLOT_W'(o));
                always_ff @(posedge clk) begin
                    if (rst) begin
                        older[y][o] <= 1'b0;
                    end else if (row_alloc) begin
                        older[y][o] <= survive[o];
                    end else if (col_alloc || touch_free) begin
                        older[y][o] <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/mo_hazard_eval.sv
`timescale 1ns/1ps
module mo_hazard_eval
    import mo_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int CMP_BITS  = 4
) (
    input  logic [NUM_SLOTS-1:0]                slot_valid,
    input  mem_kind_e [NUM_SLOTS-1:0]           slot_kind,
    input  logic [NUM_SLOTS-1:0]                slot_fence,
    input  logic [NUM_SLOTS-1:0][CMP_BITS-1:0]  slot_tag,
    input  logic [NUM_SLOTS-1:0][NUM_SLOTS-1:0] older,
    output logic [NUM_SLOTS-1:0]                rd_permit,
    output logic [NUM_SLOTS-1:0]                wr_permit
);

    logic [NUM_SLOTS-1:0][NUM_SLOTS-1:0] wait_on;
    logic [NUM_SLOTS-1:0]                held;

    for (genvar y = 0; y < NUM_SLOTS; y++) begin : g_young
        for (genvar o = 0; o < NUM_SLOTS; o++) begin : g_old
            assign wait_on[y][o] = older[y][o] && slot_valid[o] &&
                must_wait(slot_kind[y], slot_kind[o], slot_fence[y],
                          slot_tag[y] == slot_tag[o]);
        end
        assign held[y]      = |wait_on[y];
        assign rd_permit[y] = slot_valid[y] && !held[y] && (slot_kind[y] == MEM_LOAD);
        assign wr_permit[y] = slot_valid[y] && !held[y] && (slot_kind[y] == MEM_STORE);
    end

endmodule

// File: rtl/mo_order_matrix.sv
`timescale 1ns/1ps
module mo_order_matrix
    import mo_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 16,
    parameter int CMP_BITS  = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alloc_en,
    input  logic [SLOT_W-1:0]    alloc_slot,
    input  logic                 alloc_store,
    input  logic                 alloc_fence,
    input  logic [ADDR_W-1:0]    alloc_addr,
    input  logic                 free_en,
    input  logic [SLOT_W-1:0]    free_slot,
    output logic [NUM_SLOTS-1:0] rd_permit,
    output logic [NUM_SLOTS-1:0] wr_permit
);

    logic                                alloc_take;
    logic [NUM_SLOTS-1:0]                slot_valid;
    mem_kind_e [NUM_SLOTS-1:0]           slot_kind;
    logic [NUM_SLOTS-1:0]                slot_fence;
    logic [NUM_SLOTS-1:0][CMP_BITS-1:0]  slot_tag;
    logic [NUM_SLOTS-1:0][NUM_SLOTS-1:0] older;

    // High address bits are deliberately dropped: the compare is conservative.
    logic unused_addr_hi;
    assign unused_addr_hi = ^alloc_addr[ADDR_W-1:CMP_BITS];

    mo_slot_file #(
        .NUM_SLOTS (NUM_SLOTS),
        .CMP_BITS  (CMP_BITS)
    ) u_slots (
        .clk         (clk),
        .rst         (rst),
        .alloc_en    (alloc_en),
        .alloc_slot  (alloc_slot),
        .alloc_kind  (mem_kind_e'(alloc_store)),
        .alloc_fence (alloc_fence),
        .alloc_tag   (alloc_addr[CMP_BITS-1:0]),
        .free_en     (free_en),
        .free_slot   (free_slot),
        .alloc_take  (alloc_take),
        .slot_valid  (slot_valid),
        .slot_kind   (slot_kind),
        .slot_fence  (slot_fence),
        .slot_tag    (slot_tag)
    );

    mo_age_matrix #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_age (
        .clk        (clk),
        .rst        (rst),
        .alloc_take (alloc_take),
        .alloc_slot (alloc_slot),
        .free_en    (free_en),
        .free_slot  (free_slot),
        .slot_valid (slot_valid),
        .older      (older)
    );

    mo_hazard_eval #(
        .NUM_SLOTS (NUM_SLOTS),
        .CMP_BITS  (CMP_BITS)
    ) u_eval (
        .slot_valid (slot_valid),
        .slot_kind  (slot_kind),
        .slot_fence (slot_fence),
        .slot_tag   (slot_tag),
        .older      (older),
        .rd_permit  (rd_permit),
        .wr_permit  (wr_permit)
    );

endmodule

// File: rtl/mo_order_matrix_chk.sv
`timescale 1ns/1ps
module mo_order_matrix_chk #(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              free_en,
    input logic [SLOT_W-1:0]                 free_slot,
    input logic [NUM_SLOTS-1:0]              rd_permit,
    input logic [NUM_SLOTS-1:0]              wr_permit,
    input logic [NUM_SLOTS-1:0]              slot_valid,
    input logic [NUM_SLOTS-1:0][NUM_SLOTS-1:0] older
);

    logic              freed_q;
    logic [SLOT_W-1:0] freed_idx_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            freed_q     <= 1'b0;
            freed_idx_q <= '0;
        end else begin
            freed_q     <= free_en && slot_valid[free_slot];
            freed_idx_q <= free_slot;
        end
    end

    // R2
    no_dual_permit_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_permit & wr_permit) == '0);

    // R8
    single_store_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_permit));

    // R12
    freed_silent_chk: assert property (@(posedge clk) disable iff (rst)
        freed_q |-> (!rd_permit[freed_idx_q] && !wr_permit[freed_idx_q]));

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_chk
        // R9
        oldest_runs_chk: assert property (@(posedge clk) disable iff (rst)
            (slot_valid[s] && ((older[s] & slot_valid) == '0))
                |-> (rd_permit[s] || wr_permit[s]));
        for (genvar t = s + 1; t < NUM_SLOTS; t++) begin : g_pair
            // R9
            age_order_chk: assert property (@(posedge clk) disable iff (rst)
                !(older[s][t] && older[t][s]));
        end
    end

endmodule

bind mo_order_matrix mo_order_matrix_chk #(
    .NUM_SLOTS (NUM_SLOTS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .free_en    (free_en),
    .free_slot  (free_slot),
    .rd_permit  (rd_permit),
    .wr_permit  (wr_permit),
    .slot_valid (slot_valid),
    .older      (older)
);

// File: tb/sim_mo_order_matrix.sv
`timescale 1ns/1ps
module sim_mo_order_matrix;

    localparam int NS = 4;
    localparam int AW = 16;
    localparam int CB = 4;
    localparam int SW = $clog2(NS);

    localparam logic [1:0] OP_IDLE  = 2'd0;
    localparam logic [1:0] OP_ALLOC = 2'd1;
    localparam logic [1:0] OP_FREE  = 2'd2;

    typedef struct packed {
        logic [1:0]    op;
        logic [SW-1:0] slot;
        logic          store;
        logic          fence;
        logic [AW-1:0] addr;
        logic [NS-1:0] exp_rd;
        logic [NS-1:0] exp_wr;
        logic [7:0]    req;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VECS [NVEC] = '{
        '{OP_ALLOC, 2'd0, 1'b1, 1'b0, 16'h1003, 4'b0000, 4'b0001, 8'd2},  // R2 lone store
        '{OP_ALLOC, 2'd1, 1'b0, 1'b0, 16'h2003, 4'b0000, 4'b0001, 8'd6},  // R6 alias in low nibble
        '{OP_IDLE,  2'd0, 1'b0, 1'b0, 16'h0000, 4'b0000, 4'b0001, 8'd9},  // R9 older store not held
        '{OP_ALLOC, 2'd2, 1'b0, 1'b0, 16'h0005, 4'b0100, 4'b0001, 8'd7},  // R7 / R5
        '{OP_ALLOC, 2'd3, 1'b1, 1'b0, 16'h0005, 4'b0100, 4'b0001, 8'd8},  // R8 store behind store
        '{OP_FREE,  2'd0, 1'b0, 1'b0, 16'h0000, 4'b0110, 4'b0000, 8'd4},  // R4 store held by load
        '{OP_FREE,  2'd2, 1'b0, 1'b0, 16'h0000, 4'b0010, 4'b1000, 8'd5},  // R5 tags differ
        '{OP_ALLOC, 2'd0, 1'b0, 1'b0, 16'h0005, 4'b0010, 4'b1000, 8'd3},  // R3 load held
        '{OP_ALLOC, 2'd1, 1'b1, 1'b0, 16'h00F3, 4'b0010, 4'b1000, 8'd11}, // R11 live slot
        '{OP_FREE,  2'd3, 1'b0, 1'b0, 16'h0000, 4'b0011, 4'b0000, 8'd3},  // R3 release
        '{OP_ALLOC, 2'd2, 1'b0, 1'b1, 16'h000F, 4'b0011, 4'b0000, 8'd10}, // R10 fence held
        '{OP_ALLOC, 2'd3, 1'b0, 1'b0, 16'h000A, 4'b1011, 4'b0000, 8'd10}, // R10 younger free
        '{OP_FREE,  2'd1, 1'b0, 1'b0, 16'h0000, 4'b1001, 4'b0000, 8'd10},
        '{OP_FREE,  2'd0, 1'b0, 1'b0, 16'h0000, 4'b1100, 4'b0000, 8'd10},
        '{OP_FREE,  2'd2, 1'b0, 1'b0, 16'h0000, 4'b1000, 4'b0000, 8'd12},
        '{OP_FREE,  2'd3, 1'b0, 1'b0, 16'h0000, 4'b0000, 4'b0000, 8'd12},
        '{OP_ALLOC, 2'd3, 1'b1, 1'b0, 16'h0001, 4'b0000, 4'b1000, 8'd2},
        '{OP_ALLOC, 2'd0, 1'b1, 1'b0, 16'h0002, 4'b0000, 4'b1000, 8'd12}, // R12 reuse is youngest
        '{OP_FREE,  2'd3, 1'b0, 1'b0, 16'h0000, 4'b0000, 4'b0001, 8'd12},
        '{OP_FREE,  2'd0, 1'b0, 1'b0, 16'h0000, 4'b0000, 4'b0000, 8'd12}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          alloc_en = 1'b0;
    logic [SW-1:0] alloc_slot = '0;
    logic          alloc_store = 1'b0;
    logic          alloc_fence = 1'b0;
    logic [AW-1:0] alloc_addr = '0;
    logic          free_en = 1'b0;
    logic [SW-1:0] free_slot = '0;
    logic [NS-1:0] rd_permit;
    logic [NS-1:0] wr_permit;

    int applied = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    mo_order_matrix #(
        .NUM_SLOTS (NS),
        .ADDR_W    (AW),
        .CMP_BITS  (CB)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .alloc_en    (alloc_en),
        .alloc_slot  (alloc_slot),
        .alloc_store (alloc_store),
        .alloc_fence (alloc_fence),
        .alloc_addr  (alloc_addr),
        .free_en     (free_en),
        .free_slot   (free_slot),
        .rd_permit   (rd_permit),
        .wr_permit   (wr_permit)
    );

    task automatic check(input string tag, input logic [NS-1:0] er, input logic [NS-1:0] ew);
        applied++;
        if (rd_permit !== er || wr_permit !== ew) begin
            misses++;
            $display("FAIL %s: rd=%b wr=%b expected rd=%b wr=%b", tag, rd_permit, wr_permit, er, ew);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic step(input logic ae, input logic [SW-1:0] as, input logic st,
                        input logic fe, input logic [AW-1:0] ad,
                        input logic fr, input logic [SW-1:0] fs);
        alloc_en = ae; alloc_slot = as; alloc_store = st; alloc_fence = fe; alloc_addr = ad;
        free_en = fr; free_slot = fs;
        @(posedge clk);
        @(negedge clk);
        alloc_en = 1'b0; free_en = 1'b0; alloc_fence = 1'b0;
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 during reset", 4'b0000, 4'b0000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 4'b0000, 4'b0000);

        for (int v = 0; v < NVEC; v++) begin
            vec_t cur;
            string tag;
            cur = VECS[v];
            step(cur.op == OP_ALLOC, cur.slot, cur.store, cur.fence, cur.addr,
                 cur.op == OP_FREE, cur.slot);
            tag = $sformatf("R%0d vector %0d", cur.req, v);
            check(tag, cur.exp_rd, cur.exp_wr);
        end

        // R1: reset in the middle of traffic empties every slot and age bit
        step(1'b1, 2'd0, 1'b1, 1'b0, 16'h0009, 1'b0, 2'd0);
        step(1'b1, 2'd1, 1'b0, 1'b0, 16'h0009, 1'b0, 2'd0);
        check("R3 load behind store before reset", 4'b0000, 4'b0001);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-run reset", 4'b0000, 4'b0000);
        step(1'b1, 2'd1, 1'b0, 1'b0, 16'h0009, 1'b0, 2'd0);
        check("R1 no stale age after reset", 4'b0010, 4'b0000);
        step(1'b0, 2'd0, 1'b0, 1'b0, 16'h0000, 1'b1, 2'd1);

        // R12: free and allocation in the same cycle
        step(1'b1, 2'd0, 1'b1, 1'b0, 16'h0007, 1'b0, 2'd0);
        check("R2 store alone", 4'b0000, 4'b0001);
        step(1'b1, 2'd1, 1'b0, 1'b0, 16'h0007, 1'b1, 2'd0);
        check("R12 same-cycle free not older", 4'b0010, 4'b0000);
        step(1'b0, 2'd0, 1'b0, 1'b0, 16'h0000, 1'b1, 2'd1);
        check("R12 all freed", 4'b0000, 4'b0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
        $finish;
    end

endmodule